// File: doc/BRIEF.md
# Serial Programming Row-Erase Sequencer

This block is a host-side controller that erases the code memory of a target device one row at a time over a two-wire serial programming link. One output is the serial clock. The other is the serial data, which the target reads as an input. Every exchange on the link is a 20-bit frame: a 4-bit command followed by a 16-bit payload. Every frame this block sends uses the core-instruction command, so the target executes each payload as an instruction.

After a start pulse the block sends the same words for every row. It first sends three words that select code memory, clear the configuration select and enable writes. Next it loads the 24-bit target address pointer with the start of the current row. It then sends the erase-enable word and the write-start word, followed by a no-operation frame. During that frame the fourth clock pulse is held high for a programmable erase time. The clock then stays low for a programmable discharge time before the rest of the frame is sent. Rows are 64 bytes long and start at address zero. The block steps through them until it reaches the configured last row, then raises a done pulse and returns to idle.

The serial clock rate comes from a half-period input given in system clock cycles. The erase time and the discharge time are also given in system clock cycles. All three timing inputs and the last-row input must stay stable while the block is busy.

Top module: `row_erase_seq`

## Requirements
- R1: Each frame has 20 clock pulses. The first 4 pulses carry command 0000 (core instruction), least significant bit first. The next 16 pulses carry the payload, least significant bit first. The data output changes only in the cycle where the clock rises, so each bit is stable on the falling edge.
- R2: Outside the stretched pulse, each clock high phase lasts `half_period_i` cycles. Each low phase between two bits of a frame also lasts `half_period_i` cycles. A value of 0 is treated as 1.
- R3: Every row starts with the payloads 0x8EA6, 0x9CA6 and 0x84A6, in that order.
- R4: For the row at address 0, the setup words are followed by 0x6AF8, 0x6AF7 and 0x6AF6, which clear the upper, high and low pointer bytes.
- R5: For every later row, the setup words are followed by six words: 0x0E followed by the upper address byte, then 0x6EF8; 0x0E followed by the high byte, then 0x6EF7; 0x0E followed by the low byte, then 0x6EF6.
- R6: Each row ends with 0x88A6, then 0x82A6, then the no-operation payload 0x0000.
- R7: In the no-operation frame, the 4th clock pulse stays high for exactly `erase_cycles_i` cycles. The low phase after it lasts exactly `discharge_cycles_i` cycles. The last 16 bits are then sent at the normal rate.
- R8: The row address starts at 0 and increases by 64 after each row. The sequence ends after the row whose address bits 23:6 equal bits 23:6 of `last_row_i`. Bits 5:0 of `last_row_i` are ignored.
- R9: `busy_o` rises in the cycle after an accepted start and stays high until `done_o`. `done_o` is a one-cycle pulse, and `busy_o` is low in that same cycle. A start pulse while busy is ignored.
- R10: During reset, `pgc_o`, `pgd_o`, `busy_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin the erase run |
| half_period_i | input | HALF_W | Normal serial clock half period, in cycles |
| erase_cycles_i | input | TIME_W | Time the stretched pulse is held high, in cycles |
| discharge_cycles_i | input | TIME_W | Low hold time after the stretched pulse, in cycles |
| last_row_i | input | 24 | Byte address inside the final row to erase |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when the final row completes |
| pgc_o | output | 1 | Serial programming clock |
| pgd_o | output | 1 | Serial programming data to the target |

## Verification
If the step counter goes wrong, the target model sees an unexpected payload at the end of the affected 20-bit frame. That happens within about 40 half periods of the fault. If the row counter goes wrong, the pointer-load words of the next row carry the wrong address bytes, or the number of frames before `done_o` changes. If a timer loads the wrong value, the stretched pulse or the discharge gap of that row's no-operation frame has the wrong length, and so does a normal half period. The bench measures all of these to the exact cycle. A data bit that changes at the wrong moment shows up as a value that is unstable while the clock is high.

// File: rtl/row_erase_pkg.sv
package row_erase_pkg;
  localparam int unsigned CMD_W       = 4;
  localparam int unsigned PAY_W       = 16;
  localparam int unsigned FRAME_W     = CMD_W + PAY_W;
  localparam int unsigned STRETCH_BIT = 3;
  localparam int unsigned ADDR_W      = 24;

  localparam logic [CMD_W-1:0] CMD_CORE = 4'b0000;

  localparam logic [PAY_W-1:0] W_SEL_CODE = 16'h8EA6;
  localparam logic [PAY_W-1:0] W_CLR_CFG  = 16'h9CA6;
  localparam logic [PAY_W-1:0] W_WR_EN    = 16'h84A6;
  localparam logic [PAY_W-1:0] W_CLR_U    = 16'h6AF8;
  localparam logic [PAY_W-1:0] W_CLR_H    = 16'h6AF7;
  localparam logic [PAY_W-1:0] W_CLR_L    = 16'h6AF6;
  localparam logic [7:0]       W_LIT_HI   = 8'h0E;
  localparam logic [PAY_W-1:0] W_MOV_U    = 16'h6EF8;
  localparam logic [PAY_W-1:0] W_MOV_H    = 16'h6EF7;
  localparam logic [PAY_W-1:0] W_MOV_L    = 16'h6EF6;
  localparam logic [PAY_W-1:0] W_FREE     = 16'h88A6;
  localparam logic [PAY_W-1:0] W_WR       = 16'h82A6;
  localparam logic [PAY_W-1:0] W_NOP      = 16'h0000;

  typedef enum logic [3:0] {
    ST_SEL, ST_CFG, ST_WREN,
    ST_A0, ST_A1, ST_A2, ST_A3, ST_A4, ST_A5,
    ST_FREE, ST_WR, ST_NOP
  } step_e;

  typedef enum logic [1:0] {SH_IDLE, SH_HIGH, SH_LOW} shift_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_e;
endpackage

// File: rtl/erase_shifter.sv
module erase_shifter
  import row_erase_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned TIME_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [PAY_W-1:0]  data_i,
  input  logic              stretch_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [TIME_W-1:0] erase_i,
  input  logic [TIME_W-1:0] disch_i,
  output logic              pgc_o,
  output logic              pgd_o,
  output logic              done_o
);
  localparam int unsigned BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] STR_BIT  = BIT_W'(STRETCH_BIT);

  shift_state_e       st_q;
  logic [FRAME_W-1:0] sr_q;
  logic [BIT_W-1:0]   bit_q;
  logic [TIME_W-1:0]  cnt_q;
  logic               stretch_q, pgc_q, pgd_q, done_q;
  logic [BIT_W-1:0]   bit_nx;

  function automatic logic [TIME_W-1:0] ld(input logic [TIME_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign bit_nx = bit_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SH_IDLE;
      sr_q      <= '0;
      bit_q     <= '0;
      cnt_q     <= '0;
      stretch_q <= 1'b0;
      pgc_q     <= 1'b0;
      pgd_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SH_IDLE: if (go_i) begin
          sr_q      <= {data_i, cmd_i};
          stretch_q <= stretch_i;
          bit_q     <= '0;
          pgc_q     <= 1'b1;
          pgd_q     <= cmd_i[0];
          cnt_q     <= ld(TIME_W'(half_i));
          st_q      <= SH_HIGH;
        end
        SH_HIGH: begin
          if (cnt_q == '0) begin
            pgc_q <= 1'b0;
            cnt_q <= (stretch_q && bit_q == STR_BIT) ? ld(disch_i) : ld(TIME_W'(half_i));
            st_q  <= SH_LOW;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SH_LOW: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (bit_q == LAST_BIT) begin
            done_q <= 1'b1;
            st_q   <= SH_IDLE;
          end else begin
            bit_q <= bit_nx;
            sr_q  <= sr_q >> 1;
            pgd_q <= sr_q[1];
            pgc_q <= 1'b1;
            cnt_q <= (stretch_q && bit_nx == STR_BIT) ? ld(erase_i) : ld(TIME_W'(half_i));
            st_q  <= SH_HIGH;
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign pgc_o  = pgc_q;
  assign pgd_o  = pgd_q;
  assign done_o = done_q;

  // data may only move together with a rising clock
  assert_pgd_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pgd_q) |-> $rose(pgc_q));

  // sequencer never issues a frame into a busy shifter
  assert_go_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> st_q == SH_IDLE);
endmodule

// File: rtl/erase_row_ctr.sv
module erase_row_ctr
  import row_erase_pkg::*;
#(
  parameter int unsigned ROW_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] last_row_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              first_o,
  output logic              last_o
);
  localparam int unsigned ROW_LSB = $clog2(ROW_BYTES);

  logic [ADDR_W-ROW_LSB-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        row_q <= '0;
    else if (clear_i)   row_q <= '0;
    else if (advance_i) row_q <= row_q + 1'b1;
  end

  assign addr_o  = {row_q, {ROW_LSB{1'b0}}};
  assign first_o = (row_q == '0);
  assign last_o  = (row_q == last_row_i[ADDR_W-1:ROW_LSB]);
endmodule

// File: rtl/erase_step_seq.sv
module erase_step_seq
  import row_erase_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tx_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              first_i,
  input  logic              last_i,
  output logic              go_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [PAY_W-1:0]  word_o,
  output logic              stretch_o,
  output logic              clear_o,
  output logic              advance_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e st_q;
  step_e      step_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      step_q <= ST_SEL;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          step_q <= ST_SEL;
          st_q   <= SQ_ISSUE;
        end
        SQ_ISSUE: st_q <= SQ_WAIT;
        SQ_WAIT: if (tx_done_i) begin
          if (step_q == ST_NOP) begin
            step_q <= ST_SEL;
            if (last_i) begin
              done_q <= 1'b1;
              st_q   <= SQ_IDLE;
            end else begin
              st_q <= SQ_ISSUE;
            end
          end else begin
            step_q <= (step_q == ST_A2 && first_i) ? ST_FREE : step_e'(step_q + 1'b1);
            st_q   <= SQ_ISSUE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (step_q)
      ST_SEL:  word_o = W_SEL_CODE;
      ST_CFG:  word_o = W_CLR_CFG;
      ST_WREN: word_o = W_WR_EN;
      ST_A0:   word_o = first_i ? W_CLR_U : {W_LIT_HI, addr_i[23:16]};
      ST_A1:   word_o = first_i ? W_CLR_H : W_MOV_U;
      ST_A2:   word_o = first_i ? W_CLR_L : {W_LIT_HI, addr_i[15:8]};
      ST_A3:   word_o = W_MOV_H;
      ST_A4:   word_o = {W_LIT_HI, addr_i[7:0]};
      ST_A5:   word_o = W_MOV_L;
      ST_FREE: word_o = W_FREE;
      ST_WR:   word_o = W_WR;
      default: word_o = W_NOP;
    endcase
  end

  assign cmd_o     = CMD_CORE;
  assign go_o      = (st_q == SQ_ISSUE);
  assign stretch_o = (step_q == ST_NOP);
  assign clear_o   = (st_q == SQ_IDLE) && start_i;
  assign advance_o = (st_q == SQ_WAIT) && tx_done_i && (step_q == ST_NOP) && !last_i;
  assign busy_o    = (st_q != SQ_IDLE);
  assign done_o    = done_q;

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> busy_o);

  // the run may only finish on the configured final row
  assert_done_last_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> last_i);

  assert_row_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_WAIT && tx_done_i && step_q == ST_NOP && !last_i) |=> step_q == ST_SEL);
endmodule

// File: rtl/row_erase_seq.sv
module row_erase_seq
  import row_erase_pkg::*;
#(
  parameter int unsigned HALF_W    = 8,
  parameter int unsigned TIME_W    = 24,
  parameter int unsigned ROW_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HALF_W-1:0] half_period_i,
  input  logic [TIME_W-1:0] erase_cycles_i,
  input  logic [TIME_W-1:0] discharge_cycles_i,
  input  logic [23:0]       last_row_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pgc_o,
  output logic              pgd_o
);
  logic              go, stretch, tx_done, clear, advance, first_row, last_row;
  logic [CMD_W-1:0]  cmd;
  logic [PAY_W-1:0]  word;
  logic [ADDR_W-1:0] addr;

  erase_step_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .tx_done_i(tx_done),
    .addr_i   (addr),
    .first_i  (first_row),
    .last_i   (last_row),
    .go_o     (go),
    .cmd_o    (cmd),
    .word_o   (word),
    .stretch_o(stretch),
    .clear_o  (clear),
    .advance_o(advance),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  erase_row_ctr #(.ROW_BYTES(ROW_BYTES)) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .advance_i (advance),
    .last_row_i(last_row_i),
    .addr_o    (addr),
    .first_o   (first_row),
    .last_o    (last_row)
  );

  erase_shifter #(.HALF_W(HALF_W), .TIME_W(TIME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .cmd_i  (cmd),
    .data_i (word),
    .stretch_i(stretch),
    .half_i (half_period_i),
    .erase_i(erase_cycles_i),
    .disch_i(discharge_cycles_i),
    .pgc_o  (pgc_o),
    .pgd_o  (pgd_o),
    .done_o (tx_done)
  );

  assert_clk_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pgc_o);
endmodule

// File: tb/row_erase_seq_test.sv
module row_erase_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  half_p = 8'd1;
  logic [23:0] erase_c = 24'd1;
  logic [23:0] disch_c = 24'd1;
  logic [23:0] last_row = '0;
  logic        busy, done, pgc, pgd;

  always #2.5 clk = ~clk;

  row_erase_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .half_period_i(half_p), .erase_cycles_i(erase_c), .discharge_cycles_i(disch_c),
    .last_row_i(last_row), .busy_o(busy), .done_o(done), .pgc_o(pgc), .pgd_o(pgd)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // target model state
  logic [19:0] tx_word [64];
  int          tx_hi4  [64];
  int          tx_lo4  [64];
  bit          tx_bad  [64];
  int          ntx = 0;
  int          done_cnt = 0;
  int          cur_h = 1;
  bit          in_tx = 0, prev_c = 0, bad_f = 0, bit_val = 0;
  int          bitn = 0, hilen = 0, lowlen = 0, hi4 = 0, lo4 = 0;
  logic [19:0] acc = '0;

  logic [15:0] exp_w [64];
  bit          exp_s [64];
  int          nexp = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_c = 0; in_tx = 0;
    end else begin
      if (done) begin
        done_cnt++;
        if (busy) begin
          errors++; checks++;
          $display("FAIL R9: busy=%0d while done, expected 0", busy);
        end
      end
      if (pgc) begin
        if (!prev_c) begin
          if (!in_tx) begin
            in_tx = 1; bitn = 0; acc = '0; bad_f = 0;
          end else if (bitn == 4) lo4 = lowlen;
          else if (lowlen != cur_h) bad_f = 1;
          bit_val = pgd; hilen = 1;
        end else begin
          hilen++;
          if (pgd != bit_val) bad_f = 1;
        end
      end else if (prev_c) begin
        acc[bitn] = bit_val;
        if (bitn == 3) hi4 = hilen;
        else if (hilen != cur_h) bad_f = 1;
        lowlen = 1; bitn++;
        if (bitn == 20) begin
          if (ntx < 64) begin
            tx_word[ntx] = acc; tx_hi4[ntx] = hi4; tx_lo4[ntx] = lo4; tx_bad[ntx] = bad_f;
          end
          ntx++; in_tx = 0;
        end
      end else lowlen++;
      prev_c = pgc;
    end
  end

  task automatic build(input logic [23:0] last);
    int rows;
    logic [23:0] a;
    nexp = 0;
    rows = int'(last[23:6]) + 1;
    for (int r = 0; r < rows; r++) begin
      a = 24'(r * 64);
      exp_w[nexp] = 16'h8EA6; exp_s[nexp++] = 0;
      exp_w[nexp] = 16'h9CA6; exp_s[nexp++] = 0;
      exp_w[nexp] = 16'h84A6; exp_s[nexp++] = 0;
      if (r == 0) begin
        exp_w[nexp] = 16'h6AF8; exp_s[nexp++] = 0;
        exp_w[nexp] = 16'h6AF7; exp_s[nexp++] = 0;
        exp_w[nexp] = 16'h6AF6; exp_s[nexp++] = 0;
      end else begin
        exp_w[nexp] = {8'h0E, a[23:16]}; exp_s[nexp++] = 0;
        exp_w[nexp] = 16'h6EF8;          exp_s[nexp++] = 0;
        exp_w[nexp] = {8'h0E, a[15:8]};  exp_s[nexp++] = 0;
        exp_w[nexp] = 16'h6EF7;          exp_s[nexp++] = 0;
        exp_w[nexp] = {8'h0E, a[7:0]};   exp_s[nexp++] = 0;
        exp_w[nexp] = 16'h6EF6;          exp_s[nexp++] = 0;
      end
      exp_w[nexp] = 16'h88A6; exp_s[nexp++] = 0;
      exp_w[nexp] = 16'h82A6; exp_s[nexp++] = 0;
      exp_w[nexp] = 16'h0000; exp_s[nexp++] = 1;
    end
  endtask

  task automatic run_case(input logic [23:0] last, input int h, input int e, input int d,
                          input int restart_at);
    int cyc = 0;
    bit seen = 0;
    build(last);
    @(posedge clk); #1;
    last_row = last; half_p = 8'(h); erase_c = 24'(e); disch_c = 24'(d);
    cur_h = h; ntx = 0; done_cnt = 0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!seen && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (cyc == restart_at) begin
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
      end
      if (done) seen = 1;
    end
    chk(seen, "R9 done reached (timeout)", seen, 1);
    repeat (4 * h + 4) @(negedge clk);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    chk(busy == 1'b0, "R9 idle after done", busy, 0);
    chk(ntx == nexp, "R8 frame count", ntx, nexp);
    for (int i = 0; i < nexp && i < ntx; i++) begin
      chk(tx_word[i][3:0] == 4'b0000, "R1 command code", tx_word[i][3:0], 0);
      chk(tx_word[i][19:4] == exp_w[i], "R3 R4 R5 R6 payload order", tx_word[i][19:4], exp_w[i]);
      chk(!tx_bad[i], "R1 R2 bit timing and data stability", tx_bad[i], 0);
      if (exp_s[i]) begin
        chk(tx_hi4[i] == e, "R7 stretched high time", tx_hi4[i], e);
        chk(tx_lo4[i] == d, "R7 discharge low time", tx_lo4[i], d);
      end else begin
        chk(tx_hi4[i] == h, "R2 4th pulse high", tx_hi4[i], h);
        chk(tx_lo4[i] == h, "R2 4th pulse low", tx_lo4[i], h);
      end
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pgc == 0 && pgd == 0, "R10 link lines in reset", {pgc, pgd}, 0);
    chk(busy == 0 && done == 0, "R10 status in reset", {busy, done}, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_single_row();
    run_case(24'h000000, 2, 9, 6, -1);
  endtask

  task automatic test_multi_row();
    // R8: low bits of last_row ignored, rows 0, 64, 128
    run_case(24'h0000BF, 1, 4, 3, -1);
  endtask

  task automatic test_start_while_busy();
    // R9: second start mid-run must not restart or extend the run
    run_case(24'h000040, 3, 7, 5, 150);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    test_reset();
    test_single_row();
    test_multi_row();
    test_start_while_busy();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      summary();
      $finish;
    end
  end
endmodule